// File: doc/BRIEF.md
# Windowed Watchdog Reset Timer

This block watches over software with a 7-bit countdown. A free-running prescaler divides the input clock so that the count steps down once every `PRESC_DIV` cycles, which is 16384 by default. Once the watchdog is armed, the block raises a reset request in two cases. The first is a timeout: software lets the count fall out of the upper half of its range, so the top count bit clears. The second is an early reload: software refreshes the count while it is still above a programmed window value. Refreshes are therefore accepted only inside a window. With 0x7F down to 0x40 usable, the timeout can be set in 64 steps.

Software writes a control word made of an arm bit and a 7-bit count, and writes a separate 7-bit window value. The watchdog can also be armed by a strap input. A second strap turns the execution of a halt instruction into a reset cause. Every reset cause gives an active-low pulse that lasts exactly `PULSE_CYCLES` clock cycles. After the pulse the block is back in its post-reset state.

Top module: `winWatchdog`

## Requirements
- R1: After reset `wdgRstN` is 1, `cntVal` is 0x7F, the window value is 0x7F and the watchdog is disarmed.
- R2: Unless a write or a reset pulse intervenes, `cntVal` decreases by exactly one every `PRESC_DIV` cycles and wraps from 0x00 to 0x7F.
- R3: While armed (arm bit set, or `hwEnableStrap` at 1), the count reaching a value with bit 6 clear (0x40 stepping to 0x3F) starts a reset pulse one cycle later. The count stays frozen at 0x3F while the pulse lasts.
- R4: While armed, a control write made when the count is above the window value starts a reset pulse on the next cycle. The written count is not loaded.
- R5: A control write that is not early loads `ctrlWrData[6:0]` into the count and clears the prescaler. The next decrement then comes `PRESC_DIV` cycles after the load. A count equal to the window value is still inside the window.
- R6: `ctrlWrData[7]` = 1 arms the watchdog. A later write with bit 7 at 0 does not disarm it, and only the end of a reset pulse or a system reset clears it.
- R7: `hwEnableStrap` at 1 arms the watchdog without the arm bit, so it makes early reloads and timeouts cause resets.
- R8: `haltExec` starts a reset pulse on the next cycle only while the watchdog is armed and `haltResetStrap` is 1. It has no effect otherwise.
- R9: While disarmed, no reset pulse is produced, even when the count falls below 0x40 and wraps.
- R10: Every reset pulse holds `wdgRstN` at 0 for exactly `PULSE_CYCLES` cycles.
- R11: When a pulse ends, the count and the window value return to 0x7F and the arm bit is cleared.
- R12: Control and window writes made during a reset pulse are ignored.
- R13: A single write that arms the watchdog and loads a count below 0x40 starts a reset pulse two cycles after the write is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 8 | Bit 7 arms the watchdog; bits 6:0 hold the new count |
| winWrEn | input | 1 | Window value write strobe |
| winWrData | input | 7 | New window value |
| hwEnableStrap | input | 1 | Hardware arming strap |
| haltExec | input | 1 | One-cycle strobe: a halt instruction executed |
| haltResetStrap | input | 1 | Strap that makes a halt cause a reset |
| wdgRstN | output | 1 | Active-low reset pulse |
| cntVal | output | 7 | Current count, for control register readback |

## Verification
The count is first left free-running while disarmed, long enough to cross 0x40 and wrap. Only the decrement rate shows there, and no pulse may appear, which separates an armed timer from a disarmed one. Reloads are then made in three positions: above the window, exactly at the window value, and with the window at its default. Only the first may cause a pulse, which shows that the comparison is strictly greater-than. Reset causes are also driven one at a time: timeout, arm bit combined with a low count, halt with and without its strap, and strap-only arming. Each expected pulse is queued with its exact cycle, so a pulse that comes from the wrong cause or that is one cycle off is reported.

// File: rtl/wdgPkg.sv
package wdgPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadCnt;   // accept a reload of the count
    logic loadWin;   // accept a window write
    logic restore;   // last pulse cycle: return to initial values
    logic freeze;    // reset pulse in progress: hold all state
  } dpStrobe_t;
endpackage

// File: rtl/wdgDatapath.sv
module wdgDatapath
  import wdgPkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int PRESC_DIV = 16384
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] cntLoadVal,
  input  logic [CNT_W-1:0] winLoadVal,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] window
);
  localparam int PRESC_W = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(PRESC_DIV - 1);

  logic [PRESC_W-1:0] presc;
  logic               tick;

  assign tick = (presc == PRESC_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc <= '0;
    end else if (strobe.restore || strobe.loadCnt) begin
      presc <= '0;
    end else if (!strobe.freeze) begin
      presc <= tick ? '0 : presc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '1;
    end else if (strobe.restore) begin
      cnt <= '1;
    end else if (!strobe.freeze) begin
      if (strobe.loadCnt) cnt <= cntLoadVal;
      else if (tick)      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      window <= '1;
    end else if (strobe.restore) begin
      window <= '1;
    end else if (strobe.loadWin) begin
      window <= winLoadVal;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tick && !strobe.loadCnt && !strobe.restore |=> $stable(cnt)); // R2
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.freeze && !strobe.restore |=> $stable(cnt) && $stable(window)); // R12
  AST_RESTORED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restore |=> (cnt == '1) && (window == '1)); // R11
endmodule

// File: rtl/wdgControl.sv
module wdgControl
  import wdgPkg::*;
#(
  parameter int CNT_W        = 7,
  parameter int PULSE_CYCLES = 7500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWrEn,
  input  logic             ctrlActSet,
  input  logic             winWrEn,
  input  logic             hwEnableStrap,
  input  logic             haltExec,
  input  logic             haltResetStrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] window,
  output dpStrobe_t        strobe,
  output logic             pulsing
);
  localparam int PULSE_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [PULSE_W-1:0] PULSE_LAST = PULSE_W'(PULSE_CYCLES - 1);

  logic               actBit;
  logic               effActive;
  logic               earlyHit;
  logic               lowHit;
  logic               haltHit;
  logic               trigger;
  logic [PULSE_W-1:0] pulseLeft;

  always_comb begin
    effActive = actBit || hwEnableStrap;
    earlyHit  = ctrlWrEn && effActive && (cnt > window);
    lowHit    = effActive && !cnt[CNT_W-1];
    haltHit   = haltExec && haltResetStrap && effActive;
    trigger   = !pulsing && (earlyHit || lowHit || haltHit);

    strobe.loadCnt = ctrlWrEn && !pulsing && !trigger;
    strobe.loadWin = winWrEn && !pulsing;
    strobe.freeze  = pulsing;
    strobe.restore = pulsing && (pulseLeft == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actBit    <= 1'b0;
      pulsing   <= 1'b0;
      pulseLeft <= '0;
    end else if (pulsing) begin
      if (pulseLeft == '0) begin
        pulsing <= 1'b0;
        actBit  <= 1'b0;
      end else begin
        pulseLeft <= pulseLeft - 1'b1;
      end
    end else if (trigger) begin
      pulsing   <= 1'b1;
      pulseLeft <= PULSE_LAST;
    end else if (ctrlWrEn && ctrlActSet) begin
      actBit <= 1'b1;
    end
  end

  AST_TIMEOUT_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    !pulsing && effActive && !cnt[CNT_W-1] |=> pulsing); // R3
  AST_EARLY_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    !pulsing && ctrlWrEn && effActive && (cnt > window) |=> pulsing); // R4
  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(actBit) |-> $past(strobe.restore)); // R6
  AST_HALT_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    !pulsing && haltExec && haltResetStrap && effActive |=> pulsing); // R8
  AST_QUIET_DISARMED: assert property (@(posedge clk) disable iff (!rstN)
    !pulsing && !actBit && !hwEnableStrap |=> !pulsing); // R9
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pulsing && (pulseLeft != '0) |=> pulsing); // R10
endmodule

// File: rtl/winWatchdog.sv
module winWatchdog
  import wdgPkg::*;
#(
  parameter int CNT_W        = 7,
  parameter int PRESC_DIV    = 16384,
  parameter int PULSE_CYCLES = 7500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWrEn,
  input  logic [CNT_W:0]   ctrlWrData,
  input  logic             winWrEn,
  input  logic [CNT_W-1:0] winWrData,
  input  logic             hwEnableStrap,
  input  logic             haltExec,
  input  logic             haltResetStrap,
  output logic             wdgRstN,
  output logic [CNT_W-1:0] cntVal
);
  dpStrobe_t        strobe;
  logic             pulsing;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] window;

  wdgControl #(.CNT_W(CNT_W), .PULSE_CYCLES(PULSE_CYCLES)) uCtl (
    .clk(clk), .rstN(rstN),
    .ctrlWrEn(ctrlWrEn), .ctrlActSet(ctrlWrData[CNT_W]),
    .winWrEn(winWrEn), .hwEnableStrap(hwEnableStrap),
    .haltExec(haltExec), .haltResetStrap(haltResetStrap),
    .cnt(cnt), .window(window),
    .strobe(strobe), .pulsing(pulsing)
  );

  wdgDatapath #(.CNT_W(CNT_W), .PRESC_DIV(PRESC_DIV)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cntLoadVal(ctrlWrData[CNT_W-1:0]), .winLoadVal(winWrData),
    .cnt(cnt), .window(window)
  );

  assign wdgRstN = !pulsing;
  assign cntVal  = cnt;

  AST_RESET_OUT: assert property (@(posedge clk)
    !rstN |=> wdgRstN && (cntVal == '1)); // R1
endmodule

// File: tb/winWatchdog_test.sv
`timescale 1ns/1ps
module winWatchdog_test;
  localparam int DIV = 16;
  localparam int PW  = 20;

  typedef struct {
    int    at;
    string req;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = '0;
  logic       winWrEn = 1'b0;
  logic [6:0] winWrData = '0;
  logic       hwEnableStrap = 1'b0;
  logic       haltExec = 1'b0;
  logic       haltResetStrap = 1'b0;
  logic       wdgRstN;
  logic [6:0] cntVal;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  winWatchdog #(.CNT_W(7), .PRESC_DIV(DIV), .PULSE_CYCLES(PW)) uut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .winWrEn(winWrEn), .winWrData(winWrData), .hwEnableStrap(hwEnableStrap),
    .haltExec(haltExec), .haltResetStrap(haltResetStrap),
    .wdgRstN(wdgRstN), .cntVal(cntVal)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expectPulse(input int at, input string req);
    expItem_t it;
    it.at = at;
    it.req = req;
    expQ.push_back(it);
  endtask

  // called at a negedge; returns at the negedge after the write is sampled
  task automatic writeCtrl(input bit arm, input logic [6:0] v);
    ctrlWrEn = 1'b1;
    ctrlWrData = {arm, v};
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic writeWin(input logic [6:0] v);
    winWrEn = 1'b1;
    winWrData = v;
    @(negedge clk);
    winWrEn = 1'b0;
  endtask

  task automatic waitPulseEnd();
    while (wdgRstN) @(negedge clk);
    while (!wdgRstN) @(negedge clk);
  endtask

  // monitor: pops the expected pulse on every falling edge of the output
  bit prevOut = 1'b1;
  int lowCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevOut && !wdgRstN) begin
        lowCnt = 1;
        if (expQ.size() == 0) begin
          total++;
          bad++;
          $display("FAIL R9 unexpected pulse actual=%0d expected=none", cyc);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(cyc == e.at, e.req, cyc, e.at);
        end
      end else if (!wdgRstN) begin
        lowCnt++;
      end else if (!prevOut && wdgRstN) begin
        chk(lowCnt == PW, "R10 pulse width", lowCnt, PW);
      end
    end
    prevOut = wdgRstN;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] v0;
    int c;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(wdgRstN == 1'b1, "R1 reset out", wdgRstN, 1);
    chk(cntVal == 7'h7F, "R1 reset count", cntVal, 7'h7F);

    // R2: free-running rate while disarmed
    v0 = cntVal;
    repeat (3 * DIV) @(negedge clk);
    chk(cntVal == 7'(v0 - 3), "R2 decrement rate", cntVal, 7'(v0 - 3));

    // R9: cross 0x40 and wrap with no pulse
    repeat (130 * DIV) @(negedge clk);
    chk(wdgRstN == 1'b1, "R9 disarmed no pulse", wdgRstN, 1);
    chk(cntVal == 7'(v0 - 133), "R2 wrap count", cntVal, 7'(v0 - 133));

    // R5: reload restarts the prescaler
    writeCtrl(1'b0, 7'h55);
    chk(cntVal == 7'h55, "R5 load value", cntVal, 7'h55);
    repeat (DIV - 1) @(negedge clk);
    chk(cntVal == 7'h55, "R5 prescaler cleared", cntVal, 7'h55);
    @(negedge clk);
    chk(cntVal == 7'h54, "R5 first decrement", cntVal, 7'h54);

    // R3: arm and let it time out
    c = cyc;
    expectPulse(c + 2 + DIV * (7'h50 - 63), "R3 timeout");
    writeCtrl(1'b1, 7'h50);
    while (wdgRstN) @(negedge clk);
    chk(cntVal == 7'h3F, "R3 frozen at 0x3F", cntVal, 7'h3F);
    // R12: write during pulse ignored
    writeCtrl(1'b1, 7'h70);
    chk(cntVal == 7'h3F, "R12 write ignored", cntVal, 7'h3F);
    while (!wdgRstN) @(negedge clk);
    chk(cntVal == 7'h7F, "R11 count restored", cntVal, 7'h7F);

    // R11: disarmed after the pulse
    writeCtrl(1'b0, 7'h41);
    repeat (3 * DIV) @(negedge clk);
    chk(cntVal == 7'h3E, "R11 count runs", cntVal, 7'h3E);
    chk(wdgRstN == 1'b1, "R11 disarmed after pulse", wdgRstN, 1);

    // R4: early reload
    writeWin(7'h60);
    writeCtrl(1'b1, 7'h7F);
    c = cyc;
    expectPulse(c + 1, "R4 early reload");
    writeCtrl(1'b0, 7'h50);
    chk(cntVal == 7'h7F, "R4 value not loaded", cntVal, 7'h7F);
    waitPulseEnd();

    // R5: reload at the window value is accepted; R6: arm stays set
    writeWin(7'h60);
    writeCtrl(1'b1, 7'h7F);
    repeat (31 * DIV) @(negedge clk);
    chk(cntVal == 7'h60, "R5 at window", cntVal, 7'h60);
    writeCtrl(1'b0, 7'h7F);
    chk(cntVal == 7'h7F, "R5 boundary reload", cntVal, 7'h7F);
    chk(wdgRstN == 1'b1, "R5 no pulse at boundary", wdgRstN, 1);
    expectPulse(cyc + DIV * 64 + 1, "R6 still armed timeout");
    waitPulseEnd();

    // R13: arm and load below 0x40 at once
    c = cyc;
    expectPulse(c + 2, "R13 arm with low count");
    writeCtrl(1'b1, 7'h30);
    waitPulseEnd();

    // R8: halt without and with strap
    writeCtrl(1'b1, 7'h7F);
    haltResetStrap = 1'b0;
    haltExec = 1'b1;
    @(negedge clk);
    haltExec = 1'b0;
    repeat (3) @(negedge clk);
    chk(wdgRstN == 1'b1, "R8 halt no strap", wdgRstN, 1);
    haltResetStrap = 1'b1;
    c = cyc;
    expectPulse(c + 1, "R8 halt reset");
    haltExec = 1'b1;
    @(negedge clk);
    haltExec = 1'b0;
    waitPulseEnd();
    haltExec = 1'b1;
    @(negedge clk);
    haltExec = 1'b0;
    repeat (3) @(negedge clk);
    chk(wdgRstN == 1'b1, "R8 halt while disarmed", wdgRstN, 1);
    haltResetStrap = 1'b0;

    // R7: strap arming makes the early reload count
    hwEnableStrap = 1'b1;
    writeWin(7'h60);
    c = cyc;
    expectPulse(c + 1, "R7 strap armed early reload");
    writeCtrl(1'b0, 7'h7F);
    hwEnableStrap = 1'b0;
    while (!wdgRstN) @(negedge clk);

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R3 all expected pulses seen", expQ.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule